// File: doc/BRIEF.md
# Protection Control Byte Guard

This block sits beside the bus controller of a small serial storage array and owns the one control byte that governs write protection. The byte lives at the top address of the array space. It holds two volatile arming latches, a persistent two-bit guard field that selects how much of the array is locked against writes, and a persistent lock-enable bit. When the lock-enable bit is set and the external lock pin is held high, the lock can no longer be undone.

The bus controller raises `req_valid` each time a written data byte completes. With it come the target address, the data byte, and a flag that is high only when the whole transaction is a single-byte write aimed at the control byte. In the same cycle the block replies with an acknowledge decision and a grant decision. A granted write to the control byte is held as pending and takes effect at the next stop condition (`commit`). Array bytes are written by the controller whenever the grant is high. The current control byte is always presented on `reg_rd`, which serves single-byte reads of the top address.

A warm reset (`rst`) clears only the arming latches. The power-on reset (`por`) clears every bit. The persistent bits are modelled as flops.

Top module: `prot_ctrl_reg`

## Requirements
- R1: `por` clears the whole control byte to 0x00. `rst` clears the write-arm and config-arm latches and the pending write, and keeps lock-enable and the guard field.
- R2: `reg_rd` shows lock-enable on bit 7, guard[1] on bit 4, guard[0] on bit 3, config-arm on bit 2 and write-arm on bit 1. Bits 6, 5 and 0 read 0.
- R3: A control write of 0000001x sets write-arm. A control write of 00000000 clears both write-arm and config-arm.
- R4: A control write of 0000011x sets config-arm only while write-arm is set. Without write-arm it is denied and changes nothing.
- R5: While config-arm is set, a control write of w00yz010 loads lock-enable=w and guard=yz and clears config-arm. A control write of w00yz110 leaves every bit as it is.
- R6: A granted control write changes `reg_rd` only on the cycle after `commit`. Until then the old value is still shown.
- R7: While write-arm is clear, an array write gets neither acknowledge nor grant.
- R8: With write-arm set, an array write is acknowledged. It is denied a grant inside the guarded range: guard 01 covers 0x600–0x7FF, guard 10 covers 0x400–0x7FF, guard 11 covers the whole array, and guard 00 covers nothing.
- R9: While the lock pin and lock-enable are both high, every control write is acknowledged but not granted. A commit in that state discards any pending control write.
- R10: A control write always gets an acknowledge. Any data pattern that R3–R5 do not accept in the current state gets no grant and leaves the byte unchanged.
- R11: An array write to address 0x7FF (`req_reg` low) is treated as an ordinary array byte and never changes the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous warm reset, active high |
| por | input | 1 | Synchronous power-on reset, active high, clears persistent bits |
| hw_lock_pin | input | 1 | External lock pin |
| req_valid | input | 1 | A written data byte has completed this cycle |
| req_reg | input | 1 | The byte is a single-byte write to the control byte |
| req_addr | input | ADDR_W | Array address of the byte |
| req_data | input | 8 | Data byte |
| commit | input | 1 | Stop condition seen |
| req_ack | output | 1 | Acknowledge decision for the byte |
| req_grant | output | 1 | The write will take effect |
| reg_rd | output | 8 | Current control byte |

## Verification
The hardest state to reach from the ports is the irreversible lock. It needs the full arm, arm-again and program sequence to go through with the pin low, then the pin raised, then further attempts to rewrite the byte. The stimulus walks that chain one committed step at a time. Along the way it injects sequence errors, such as programming without config-arm, arming config without write-arm, and a warm reset between capture and commit, and checks that each of them leaves the byte untouched. A behavioural model in the bench follows every cycle and predicts acknowledge, grant and the read value.

// File: rtl/prot_pkg.sv
package prot_pkg;

    localparam int unsigned DATA_W = 8;

    typedef struct packed {
        logic       lock_en;
        logic [1:0] guard;
        logic       cfg_arm;
        logic       wr_arm;
    } prot_state_t;

    typedef enum logic [2:0] {
        OP_REJECT,
        OP_DISARM,
        OP_ARM_WR,
        OP_ARM_CFG,
        OP_PROGRAM,
        OP_KEEP
    } prot_op_e;

    function automatic logic [DATA_W-1:0] prot_pack(prot_state_t s);
        return {s.lock_en, 2'b00, s.guard, s.cfg_arm, s.wr_arm, 1'b0};
    endfunction

    function automatic prot_op_e prot_classify(logic [DATA_W-1:0] d, prot_state_t s);
        logic fixed_zero;
        fixed_zero = (d[6:5] == 2'b00);
        if (d == '0)
            return OP_DISARM;
        else if (s.cfg_arm && fixed_zero && d[2:0] == 3'b010)
            return OP_PROGRAM;
        else if (d[7:1] == 7'b0000001)
            return OP_ARM_WR;
        else if (s.wr_arm && d[7:1] == 7'b0000011)
            return OP_ARM_CFG;
        else if (s.cfg_arm && fixed_zero && d[2:0] == 3'b110)
            return OP_KEEP;
        else
            return OP_REJECT;
    endfunction

    function automatic prot_state_t prot_apply(prot_op_e op, logic [DATA_W-1:0] d, prot_state_t s);
        prot_state_t n;
        n = s;
        case (op)
            OP_DISARM:  begin n.wr_arm = 1'b0; n.cfg_arm = 1'b0; end
            OP_ARM_WR:  n.wr_arm = 1'b1;
            OP_ARM_CFG: n.cfg_arm = 1'b1;
            OP_PROGRAM: begin
                n.lock_en = d[7];
                n.guard   = d[4:3];
                n.cfg_arm = 1'b0;
            end
            default:    n = s;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/prot_range.sv
module prot_range #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        guard,
    output logic              blocked
);
    localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(3) << (ADDR_W - 2);
    localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);

    always_comb begin
        case (guard)
            2'b01:   blocked = (addr >= QTR_BASE);
            2'b10:   blocked = (addr >= HALF_BASE);
            2'b11:   blocked = 1'b1;
            default: blocked = 1'b0;
        endcase
    end
endmodule

// File: rtl/prot_decide.sv
module prot_decide
    import prot_pkg::*;
(
    input  prot_state_t       st,
    input  logic              locked,
    input  logic              req_valid,
    input  logic              req_reg,
    input  logic [DATA_W-1:0] req_data,
    input  logic              blocked,
    output logic              ack,
    output logic              grant,
    output prot_state_t       nxt
);
    prot_op_e op;

    always_comb begin
        op  = prot_classify(req_data, st);
        nxt = prot_apply(op, req_data, st);
        if (!req_valid) begin
            ack   = 1'b0;
            grant = 1'b0;
        end else if (req_reg) begin
            ack   = 1'b1;
            grant = !locked && (op != OP_REJECT);
        end else begin
            ack   = st.wr_arm;
            grant = st.wr_arm && !blocked;
        end
    end
endmodule

// File: rtl/prot_store.sv
module prot_store
    import prot_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        por,
    input  logic        capture,
    input  prot_state_t nxt,
    input  logic        commit,
    input  logic        locked,
    output prot_state_t st
);
    prot_state_t pend;
    logic        pend_v;

    always_ff @(posedge clk) begin
        if (por) begin
            st     <= '0;
            pend   <= '0;
            pend_v <= 1'b0;
        end else if (rst) begin
            st.wr_arm  <= 1'b0;
            st.cfg_arm <= 1'b0;
            pend_v     <= 1'b0;
        end else begin
            if (commit && pend_v && !locked)
                st <= pend;
            if (commit) begin
                pend_v <= 1'b0;
            end else if (capture) begin
                pend_v <= 1'b1;
                pend   <= nxt;
            end
        end
    end

    AST_NV_NEEDS_CFG: assert property (@(posedge clk) disable iff (por)
        (!$past(por) && ({st.lock_en, st.guard} != $past({st.lock_en, st.guard})))
        |-> $past(st.cfg_arm && commit)); // R5

    AST_CFG_NEEDS_WR: assert property (@(posedge clk) disable iff (por)
        (!$past(por) && $rose(st.cfg_arm)) |-> $past(st.wr_arm)); // R4
endmodule

// File: rtl/prot_ctrl_reg.sv
module prot_ctrl_reg
    import prot_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              hw_lock_pin,
    input  logic              req_valid,
    input  logic              req_reg,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic              commit,
    output logic              req_ack,
    output logic              req_grant,
    output logic [7:0]        reg_rd
);
    prot_state_t state;
    prot_state_t nxt;
    logic        blocked;
    logic        locked;

    assign locked = hw_lock_pin && state.lock_en;

    prot_range #(.ADDR_W(ADDR_W)) u_range (
        .addr    (req_addr),
        .guard   (state.guard),
        .blocked (blocked)
    );

    prot_decide u_decide (
        .st        (state),
        .locked    (locked),
        .req_valid (req_valid),
        .req_reg   (req_reg),
        .req_data  (req_data),
        .blocked   (blocked),
        .ack       (req_ack),
        .grant     (req_grant),
        .nxt       (nxt)
    );

    prot_store u_store (
        .clk     (clk),
        .rst     (rst),
        .por     (por),
        .capture (req_valid && req_reg && req_grant),
        .nxt     (nxt),
        .commit  (commit),
        .locked  (locked),
        .st      (state)
    );

    assign reg_rd = prot_pack(state);

    AST_ARRAY_NOACK: assert property (@(posedge clk) disable iff (rst || por)
        (req_valid && !req_reg && !reg_rd[1]) |-> !req_ack); // R7

    AST_GUARD_DENY: assert property (@(posedge clk) disable iff (rst || por)
        (req_valid && !req_reg && blocked) |-> !req_grant); // R8

    AST_LOCK_NOGRANT: assert property (@(posedge clk) disable iff (rst || por)
        (req_valid && req_reg && hw_lock_pin && reg_rd[7]) |-> (req_ack && !req_grant)); // R9

    AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (por)
        (!$past(por) && $past(hw_lock_pin && reg_rd[7])) |-> $stable({reg_rd[7], reg_rd[4:3]})); // R9
endmodule

// File: tb/prot_ctrl_reg_bench.sv
module prot_ctrl_reg_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b0;
    logic        por = 1'b1;
    logic        hw_lock_pin = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_reg = 1'b0;
    logic [10:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic        commit = 1'b0;
    logic        req_ack, req_grant;
    logic [7:0]  reg_rd;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // behavioural model state
    int m_wr = 0, m_cfg = 0, m_lock = 0, m_guard = 0;
    int p_v = 0, p_wr = 0, p_cfg = 0, p_lock = 0, p_guard = 0;

    always #2.5 clk = ~clk;

    prot_ctrl_reg u_prot_ctrl_reg (
        .clk(clk), .rst(rst), .por(por), .hw_lock_pin(hw_lock_pin),
        .req_valid(req_valid), .req_reg(req_reg), .req_addr(req_addr),
        .req_data(req_data), .commit(commit),
        .req_ack(req_ack), .req_grant(req_grant), .reg_rd(reg_rd)
    );

    task automatic check(string tag, int actual, int expected);
        vectors++;
        if (actual != expected) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, actual, expected, $time);
        end
    endtask

    function automatic int model_byte();
        return m_lock * 128 + m_guard * 8 + m_cfg * 4 + m_wr * 2;
    endfunction

    function automatic bit in_guard(int a);
        if (m_guard == 1) return a >= 1536;
        if (m_guard == 2) return a >= 1024;
        if (m_guard == 3) return 1'b1;
        return 1'b0;
    endfunction

    task automatic step(string tag, bit v, bit r, int a, int d, bit c, bit w, bit rs, bit pr);
        int e_ack, e_grant;
        int n_wr, n_cfg, n_lock, n_guard, ok;
        @(negedge clk);
        req_valid = v; req_reg = r; req_addr = 11'(a); req_data = 8'(d);
        commit = c; hw_lock_pin = w; rst = rs; por = pr;
        #1;
        n_wr = m_wr; n_cfg = m_cfg; n_lock = m_lock; n_guard = m_guard; ok = 1;
        if (!v) begin
            e_ack = 0; e_grant = 0;
        end else if (!r) begin
            e_ack = m_wr; e_grant = (m_wr != 0 && !in_guard(a)) ? 1 : 0;
        end else begin
            e_ack = 1;
            if (d == 0) begin n_wr = 0; n_cfg = 0; end
            else if (m_cfg != 0 && (d & 8'h67) == 8'h02) begin
                n_lock = d / 128; n_guard = (d / 8) % 4; n_cfg = 0;
            end
            else if (d / 2 == 1) n_wr = 1;
            else if (m_wr != 0 && d / 2 == 3) n_cfg = 1;
            else if (m_cfg != 0 && (d & 8'h67) == 8'h06) ok = 1;
            else ok = 0;
            e_grant = (ok != 0 && !(w && m_lock != 0)) ? 1 : 0;
        end
        check({tag, " ack"}, int'(req_ack), e_ack);
        check({tag, " grant"}, int'(req_grant), e_grant);
        check({tag, " byte"}, int'(reg_rd), model_byte());
        @(posedge clk);
        if (pr) begin
            m_wr = 0; m_cfg = 0; m_lock = 0; m_guard = 0; p_v = 0;
        end else if (rs) begin
            m_wr = 0; m_cfg = 0; p_v = 0;
        end else begin
            if (c && p_v != 0 && !(w && m_lock != 0)) begin
                m_wr = p_wr; m_cfg = p_cfg; m_lock = p_lock; m_guard = p_guard;
            end
            if (c) p_v = 0;
            else if (v && r && e_grant != 0) begin
                p_v = 1; p_wr = n_wr; p_cfg = n_cfg; p_lock = n_lock; p_guard = n_guard;
            end
        end
    endtask

    task automatic idle(string tag, bit w);
        step(tag, 0, 0, 0, 0, 0, w, 0, 0);
    endtask

    task automatic wreg(string tag, int d, bit w);
        step(tag, 1, 1, 2047, d, 0, w, 0, 0);
        step(tag, 0, 0, 0, 0, 1, w, 0, 0);
        idle(tag, w);
    endtask

    task automatic warr(string tag, int a);
        step(tag, 1, 0, a, 8'h5A, 0, 0, 0, 0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        step("R1 por", 0, 0, 0, 0, 0, 0, 0, 1);
        idle("R1 after por", 0);
        warr("R7 unarmed low", 11'h010);
        warr("R7 unarmed top", 11'h7FF);
        // R6: pending visible only after commit
        step("R6 capture", 1, 1, 2047, 8'h03, 0, 0, 0, 0);
        idle("R6 still old", 0);
        step("R6 commit", 0, 0, 0, 0, 1, 0, 0, 0);
        idle("R3 armed", 0);
        warr("R8 guard00 top", 11'h7FF);
        warr("R11 array top byte", 11'h7FF);
        idle("R11 byte unchanged", 0);
        wreg("R4 arm cfg", 8'h06, 0);
        wreg("R5 program g01", 8'h0A, 0);
        warr("R8 g01 below", 11'h5FF);
        warr("R8 g01 edge", 11'h600);
        wreg("R5 program no cfg", 8'h12, 0);
        wreg("R4 arm cfg again", 8'h07, 0);
        wreg("R5 keep pattern", 8'h0E, 0);
        wreg("R5 program g10", 8'h12, 0);
        warr("R8 g10 below", 11'h3FF);
        warr("R8 g10 edge", 11'h400);
        wreg("R10 bad pattern", 8'h40, 0);
        wreg("R10 bad bit0", 8'h05, 0);
        wreg("R3 disarm", 8'h00, 0);
        wreg("R4 cfg without wr", 8'h06, 0);
        warr("R7 disarmed", 11'h000);
        wreg("R3 arm", 8'h02, 0);
        wreg("R4 arm cfg", 8'h06, 0);
        step("R1 warm reset", 0, 0, 0, 0, 0, 0, 1, 0);
        idle("R1 guard kept", 0);
        // R1: pending dropped by warm reset
        wreg("R3 arm", 8'h02, 0);
        step("R1 capture", 1, 1, 2047, 8'h00, 0, 0, 0, 0);
        step("R1 reset mid", 0, 0, 0, 0, 0, 0, 1, 0);
        step("R1 late commit", 0, 0, 0, 0, 1, 0, 0, 0);
        idle("R1 unchanged", 0);
        wreg("R3 arm", 8'h02, 0);
        wreg("R4 arm cfg", 8'h06, 0);
        wreg("R5 program lock g11", 8'h9A, 0);
        warr("R8 g11 bottom", 11'h000);
        // R9: lock pin high
        wreg("R9 locked disarm", 8'h00, 1);
        wreg("R9 locked arm cfg", 8'h06, 1);
        warr("R9 locked array", 11'h000);
        // R9: pending captured unlocked, commit while locked is dropped
        step("R9 capture", 1, 1, 2047, 8'h00, 0, 0, 0, 0);
        step("R9 commit locked", 0, 0, 0, 0, 1, 1, 0, 0);
        idle("R9 frozen", 1);
        wreg("R9 pin low disarm", 8'h00, 0);
        idle("R2 layout", 0);
        step("R1 por clears", 0, 0, 0, 0, 0, 0, 0, 1);
        idle("R1 zero", 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule